// File: doc/BRIEF.md
# Trimmable-Rate Time-of-Day Counter

This block keeps a 64-bit time count in ticks of 8 ns and lets software speed it up or slow it down by a small amount. A 32-bit rate word sets the average increment per clock cycle. The value 2^31 means exactly one tick per cycle. A phase accumulator turns the fractional part of the rate into occasional extra or skipped ticks. Every write to the rate word is clamped to about ±3.2% of nominal.

Software reaches the block through a plain word-wide register port. The 64-bit value is written in two halves. The high half commits the write. Depending on a level bit in the command word, the commit either replaces the count or adds a signed offset to it. Reads of the count take a snapshot: reading the low half latches the high half, so the two halves always belong to the same sample. The command word also carries a clear bit, a timestamp-select level bit, and four self-clearing strobes for a schedule engine and a pin generator downstream.

Top module: `ptp_clock_core`

## Requirements
- R1: After reset the count is 0, the rate word reads 0x80000000, the timestamp-select output is 1 and the write mode is load (command readback 0x00000004).
- R2: Each cycle the count advances by the integer carry of a 31-bit fractional accumulator plus the rate word. Over 32·k cycles at rate 0x80000000 ± 0x04000000 the count moves by exactly 32·k ± k, and at 0x80000000 it moves by one per cycle.
- R3: A write to the rate register (address 1) stores the value saturated to the range [0x7BE76C8B, 0x84189375]. A read of address 1 returns the stored value.
- R4: A write to address 2 stages the low 32 bits of a value. A write to address 3 commits {data, staged low}. In load mode (command bit 0 = 0), the count equals the committed value in the cycle after the commit.
- R5: In add mode (command bit 0 = 1), a commit sets the count to the previous count plus the committed value, taken as two's complement, plus that cycle's normal increment.
- R6: Read data appears on rdata_o in the cycle after rd_en_i. A read of address 2 returns the current low word and latches the high word. A later read of address 3 returns that latched high word, even if the count has carried into the high half since.
- R7: A write to the command register (address 0) with bit 31 clear has no effect: no strobe fires, the count is not cleared and the level bits keep their values.
- R8: A valid command write with bit 3 set clears the count and the fractional phase, so the count reads 0 in the next cycle.
- R9: In a valid command write, bits 30, 29, 28 and 27 drive sched_start_o, sched_stop_o, pin_start_o and pin_stop_o high for exactly one cycle after the write.
- R10: Command bits 2 (timestamp select, on ts_corr_o) and 0 (add mode) are taken from every valid command write and held until the next one. A read of address 0 returns them in bit positions 2 and 0, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 command, 1 rate, 2 value low, 3 value high |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| time_o | output | 64 | Live tick count |
| ts_corr_o | output | 1 | Timestamp-select level bit |
| sched_start_o | output | 1 | One-cycle schedule start strobe |
| sched_stop_o | output | 1 | One-cycle schedule stop strobe |
| pin_start_o | output | 1 | One-cycle pin output start strobe |
| pin_stop_o | output | 1 | One-cycle pin output stop strobe |

## Verification
The properties assume that wr_en_i and rd_en_i are never high in the same cycle. They also assume that the address and data are steady for the whole cycle in which a strobe is high. The step-size property relies on the rate clamp, so the count can never advance by more than two ticks per cycle. The bench keeps to these assumptions: every access is a single-cycle strobe, driven at the falling edge and released one cycle later. It also chooses rate offsets whose phase sum is a whole number of wraps over the measured window, so each expected delta is exact whatever the starting phase.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;
  typedef enum logic [1:0] {
    ADR_CMD  = 2'd0,
    ADR_RATE = 2'd1,
    ADR_VLO  = 2'd2,
    ADR_VHI  = 2'd3
  } reg_addr_e;

  // command word bit positions (software decodes these)
  localparam int unsigned CB_VALID  = 31;
  localparam int unsigned CB_STROBE = 30;  // 30..27: sched start/stop, pin start/stop
  localparam int unsigned N_STROBE  = 4;
  localparam int unsigned CB_CLR    = 3;
  localparam int unsigned CB_TSC    = 2;
  localparam int unsigned CB_ADD    = 0;
endpackage

// File: rtl/ptp_rate_reg.sv
module ptp_rate_reg #(
  parameter int unsigned W         = 32,
  parameter logic [W-1:0] SPAN     = 32'h0418_9375
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rate_o
);
  localparam logic [W-1:0] NOM  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] RMIN = NOM - SPAN;
  localparam logic [W-1:0] RMAX = NOM + SPAN;

  logic [W-1:0] rate_q, rate_d;

  always_comb begin
    if (wdata_i < RMIN)      rate_d = RMIN;
    else if (wdata_i > RMAX) rate_d = RMAX;
    else                     rate_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rate_q <= NOM;
    else if (we_i) rate_q <= rate_d;
  end

  assign rate_o = rate_q;
endmodule

// File: rtl/ptp_phase_acc.sv
module ptp_phase_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] rate_i,
  output logic [1:0]   inc_o
);
  localparam int unsigned FRAC_W = W - 1;

  logic [FRAC_W-1:0] acc_q;
  logic [W:0]        sum;

  // integer part of (phase + rate/2^31) is the tick step
  assign sum   = {2'b00, acc_q} + {1'b0, rate_i};
  assign inc_o = sum[W:W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/ptp_tick_counter.sv
module ptp_tick_counter #(
  parameter int unsigned TW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic          add_i,
  input  logic [TW-1:0] val_i,
  input  logic [1:0]    inc_i,
  output logic [TW-1:0] cnt_o
);
  logic [TW-1:0] cnt_q, step;

  assign step = {{(TW-2){1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (add_i)  cnt_q <= cnt_q + val_i + step;
    else             cnt_q <= cnt_q + step;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ptp_cmd_ctrl.sv
module ptp_cmd_ctrl
  import ptp_clk_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [W-1:0]        wdata_i,
  output logic [N_STROBE-1:0] strobe_o,  // [3]=sched start .. [0]=pin stop
  output logic                clr_o,
  output logic                add_mode_o,
  output logic                ts_corr_o
);
  logic                take;
  logic                add_q, tsc_q;
  logic [N_STROBE-1:0] strobe_q;

  assign take  = we_i && wdata_i[CB_VALID];
  assign clr_o = take && wdata_i[CB_CLR];

  for (genvar k = 0; k < N_STROBE; k++) begin : g_strobe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strobe_q[N_STROBE-1-k] <= 1'b0;
      else         strobe_q[N_STROBE-1-k] <= take && wdata_i[CB_STROBE-k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add_q <= 1'b0;
      tsc_q <= 1'b1;
    end else if (take) begin
      add_q <= wdata_i[CB_ADD];
      tsc_q <= wdata_i[CB_TSC];
    end
  end

  assign strobe_o   = strobe_q;
  assign add_mode_o = add_q;
  assign ts_corr_o  = tsc_q;
endmodule

// File: rtl/ptp_clock_core.sv
module ptp_clock_core
  import ptp_clk_pkg::*;
#(
  parameter int unsigned   REG_W     = 32,
  parameter logic [31:0]   RATE_SPAN = 32'h0418_9375
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [1:0]         addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic [2*REG_W-1:0] time_o,
  output logic               ts_corr_o,
  output logic               sched_start_o,
  output logic               sched_stop_o,
  output logic               pin_start_o,
  output logic               pin_stop_o
);
  localparam int unsigned TIME_W = 2 * REG_W;

  logic                cmd_we, rate_we, vlo_we, vhi_we;
  logic [REG_W-1:0]    rate_q, lo_stage_q, snap_q, rdata_q, cmd_rd;
  logic [TIME_W-1:0]   cnt;
  logic [1:0]          inc;
  logic [N_STROBE-1:0] strobe;
  logic                clr, add_mode;

  assign cmd_we  = wr_en_i && (addr_i == ADR_CMD);
  assign rate_we = wr_en_i && (addr_i == ADR_RATE);
  assign vlo_we  = wr_en_i && (addr_i == ADR_VLO);
  assign vhi_we  = wr_en_i && (addr_i == ADR_VHI);

  ptp_cmd_ctrl #(.W(REG_W)) u_cmd (
    .clk_i, .rst_ni,
    .we_i      (cmd_we),
    .wdata_i   (wdata_i),
    .strobe_o  (strobe),
    .clr_o     (clr),
    .add_mode_o(add_mode),
    .ts_corr_o (ts_corr_o)
  );

  ptp_rate_reg #(.W(REG_W), .SPAN(RATE_SPAN[REG_W-1:0])) u_rate (
    .clk_i, .rst_ni,
    .we_i   (rate_we),
    .wdata_i(wdata_i),
    .rate_o (rate_q)
  );

  ptp_phase_acc #(.W(REG_W)) u_acc (
    .clk_i, .rst_ni,
    .clr_i (clr),
    .rate_i(rate_q),
    .inc_o (inc)
  );

  ptp_tick_counter #(.TW(TIME_W)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i (clr),
    .load_i(vhi_we && !add_mode),
    .add_i (vhi_we && add_mode),
    .val_i ({wdata_i, lo_stage_q}),
    .inc_i (inc),
    .cnt_o (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lo_stage_q <= '0;
    else if (vlo_we) lo_stage_q <= wdata_i;
  end

  always_comb begin
    cmd_rd         = '0;
    cmd_rd[CB_TSC] = ts_corr_o;
    cmd_rd[CB_ADD] = add_mode;
  end

  // registered read; low-word read snapshots the high word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      snap_q  <= '0;
    end else if (rd_en_i) begin
      unique case (addr_i)
        ADR_CMD:  rdata_q <= cmd_rd;
        ADR_RATE: rdata_q <= rate_q;
        ADR_VLO: begin
          rdata_q <= cnt[REG_W-1:0];
          snap_q  <= cnt[TIME_W-1:REG_W];
        end
        default:  rdata_q <= snap_q;
      endcase
    end
  end

  assign rdata_o       = rdata_q;
  assign time_o        = cnt;
  assign sched_start_o = strobe[3];
  assign sched_stop_o  = strobe[2];
  assign pin_start_o   = strobe[1];
  assign pin_stop_o    = strobe[0];
endmodule

// File: rtl/ptp_clock_core_chk.sv
module ptp_clock_core_chk #(
  parameter logic [31:0] RMIN = 32'h7BE7_6C8B,
  parameter logic [31:0] RMAX = 32'h8418_9375
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [1:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic [63:0] time_o,
  input logic        ts_corr_o,
  input logic [3:0]  strobes,
  input logic [31:0] rate_q,
  input logic [31:0] lo_stage_q,
  input logic        add_mode
);
  logic cmd_wr;
  assign cmd_wr = wr_en_i && (addr_i == 2'd0);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && addr_i == 2'd3) && !(cmd_wr && wdata_i[31] && wdata_i[3]))
      |=> ((time_o - $past(time_o)) <= 64'd2));

  p_rate_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_q >= RMIN) && (rate_q <= RMAX));

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd3 && !add_mode)
      |=> (time_o == {$past(wdata_i), $past(lo_stage_q)}));

  p_read_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd2) |=> (rdata_o == $past(time_o[31:0])));

  p_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !wdata_i[31]) |=> ((strobes == 4'b0) && $stable(ts_corr_o)));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[31] && wdata_i[3]) |=> (time_o == 64'd0));

  p_strobe_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((strobes != 4'b0) && !cmd_wr) |=> (strobes == 4'b0));

  p_level_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr |=> ($stable(ts_corr_o) && $stable(add_mode)));
endmodule

bind ptp_clock_core ptp_clock_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .time_o     (time_o),
  .ts_corr_o  (ts_corr_o),
  .strobes    ({sched_start_o, sched_stop_o, pin_start_o, pin_stop_o}),
  .rate_q     (rate_q),
  .lo_stage_q (lo_stage_q),
  .add_mode   (add_mode)
);

// File: tb/ptp_clock_core_tb.sv
`timescale 1ns/1ps
module ptp_clock_core_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] time_v;
  logic        ts_corr, s_start, s_stop, p_start, p_stop;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ptp_clock_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .time_o(time_v),
    .ts_corr_o(ts_corr), .sched_start_o(s_start), .sched_stop_o(s_stop),
    .pin_start_o(p_start), .pin_stop_o(p_stop)
  );

  // {rate written, expected readback, cycles to measure, expected delta}
  localparam logic [95:0] RATE_VEC [0:5] = '{
    {32'h8000_0000, 32'h8000_0000, 16'd100, 16'd100},
    {32'h8400_0000, 32'h8400_0000, 16'd320, 16'd330},
    {32'h7C00_0000, 32'h7C00_0000, 16'd320, 16'd310},
    {32'hFFFF_FFFF, 32'h8418_9375, 16'd0,   16'd0},
    {32'h0000_0000, 32'h7BE7_6C8B, 16'd0,   16'd0},
    {32'h8000_0000, 32'h8000_0000, 16'd64,  16'd64}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output logic [63:0] t_pre);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; t_pre = time_v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic [63:0] t_pre);
    @(negedge clk);
    rd_en = 1'b1; addr = a; t_pre = time_v;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] t0, t1, tl;
    logic [31:0] d;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 time in reset", time_v, 64'd0);
    chk("R1 ts_corr in reset", {63'd0, ts_corr}, 64'd1);
    chk("R1 strobes in reset", {60'd0, s_start, s_stop, p_start, p_stop}, 64'd0);
    rst_ni = 1'b1;
    rd(2'd0, d, t0); chk("R1 R10 cmd readback", {32'd0, d}, 64'h4);
    rd(2'd1, d, t0); chk("R1 rate readback", {32'd0, d}, 64'h8000_0000);

    for (int i = 0; i < 6; i++) begin
      wr(2'd1, RATE_VEC[i][95:64], t0);
      rd(2'd1, d, t0);
      chk("R3 rate clamp/readback", {32'd0, d}, {32'd0, RATE_VEC[i][63:32]});
      if (RATE_VEC[i][31:16] != 16'd0) begin
        @(negedge clk); t0 = time_v;
        repeat (int'(RATE_VEC[i][31:16])) @(posedge clk);
        @(negedge clk); t1 = time_v;
        chk("R2 rate delta", t1 - t0, {48'd0, RATE_VEC[i][15:0]});
      end
    end

    // load mode value write
    wr(2'd2, 32'hFFFF_FFF0, t0);
    wr(2'd3, 32'h0000_0000, t0);
    chk("R4 load value", time_v, 64'h0000_0000_FFFF_FFF0);

    // coherent snapshot across a carry into the high word
    rd(2'd2, d, tl);
    chk("R6 low word read", {32'd0, d}, {32'd0, tl[31:0]});
    repeat (40) @(posedge clk);
    rd(2'd3, d, t0);
    chk("R6 high word from snapshot", {32'd0, d}, {32'd0, tl[63:32]});

    // add mode
    wr(2'd0, 32'h8000_0005, t0);
    rd(2'd0, d, t0); chk("R10 add mode readback", {32'd0, d}, 64'h5);
    wr(2'd2, 32'd100, t0);
    wr(2'd3, 32'd0, t0);
    chk("R5 add positive", time_v, t0 + 64'd101);
    wr(2'd2, 32'hFFFF_FFFB, t0);
    wr(2'd3, 32'hFFFF_FFFF, t0);
    chk("R5 add negative", time_v, t0 - 64'd4);

    // command without valid bit
    wr(2'd0, 32'h0000_0008, t0);
    chk("R7 clear ignored", time_v, t0 + 64'd1);
    wr(2'd0, 32'h7800_0000, t0);
    chk("R7 strobes ignored", {60'd0, s_start, s_stop, p_start, p_stop}, 64'd0);
    rd(2'd0, d, t0); chk("R7 levels unchanged", {32'd0, d}, 64'h5);

    // clear
    wr(2'd0, 32'h8000_000C, t0);
    chk("R8 clear to zero", time_v, 64'd0);
    repeat (10) @(posedge clk);
    rd(2'd0, d, t0); chk("R10 levels held", {32'd0, d}, 64'h4);

    // strobes
    for (int k = 0; k < 4; k++) begin
      wr(2'd0, 32'h8000_0004 | (32'h1 << (30 - k)), t0);
      chk("R9 strobe high", {60'd0, s_start, s_stop, p_start, p_stop}, 64'(4'b1000 >> k));
      @(posedge clk); @(negedge clk);
      chk("R9 strobe self-clears", {60'd0, s_start, s_stop, p_start, p_stop}, 64'd0);
    end

    wr(2'd0, 32'h8000_0000, t0);
    chk("R10 ts_corr cleared", {63'd0, ts_corr}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule